// File: doc/BRIEF.md
# Two-Dimensional Associative Cache Tag Controller

This block looks up tags and chooses victims for one cache macro-block laid out as a grid of rows by columns. Any line may be placed in any entry, so the grid acts as one fully associative set. A lookup runs in two steps. First, a short partial tag (the low bits of the request tag) is compared against every valid entry at once. Second, the entries that passed are confirmed against the upper tag bits, which sit in ordinary storage.

A fill places a new tag in a victim chosen in two stages. A free-running LFSR names the row. Within that row, the victim is the lowest-numbered empty column, or the least recently used column when the row is full. The fill response returns the victim's position and its old tag so the caller can write back the displaced line. Data arrays, coherence and the next memory level sit outside this block.

Top module: `tcache_tag_ctrl`

## Requirements
- R1: A synchronous active-high reset invalidates every entry and sets each row's column ages to the column index. After reset every lookup misses, and `rsp_valid` and `fill_ack` read 0.
- R2: The partial tag is bits [11:0] of the tag and the upper part is bits [23:12]. A stored tag that agrees with the request in only one of these two fields does not produce a hit.
- R3: When exactly one valid entry holds the full request tag, the response has `rsp_hit`=1, `rsp_row` set to that entry's row and `rsp_col` set to its column. On any response without a hit, `rsp_row` and `rsp_col` read 0.
- R4: The row generator is a 7-bit shift register seeded to 7'h01 by reset. It steps on every clock out of reset to {s[5:0], s[6]^s[5]}. A fill writes into the row equal to the register value at the fill's sampling edge, so row 0 is never chosen.
- R5: Each row keeps a true LRU order of its 8 columns. A hit or a fill makes the touched column the youngest. When the chosen row has no empty column, the fill evicts the oldest column.
- R6: When the chosen row has an empty column, a fill uses the lowest-numbered empty column and evicts nothing.
- R7: When more than one valid entry holds the full request tag, the response has `rsp_multi`=1 and `rsp_hit`=0, and the LRU order is left unchanged.
- R8: One cycle after `fill_valid` is sampled, `fill_ack` pulses for one cycle. With it come the victim row and column, `fill_evict` set when the victim held a valid line, and that line's old tag on `fill_old_tag`.
- R9: A lookup sampled at edge k is answered with `rsp_valid` at edge k+2. One lookup is accepted every cycle and responses keep request order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| lk_valid | input | 1 | Lookup request strobe |
| lk_tag | input | 24 | Lookup tag |
| rsp_valid | output | 1 | Lookup response strobe |
| rsp_hit | output | 1 | Exactly one full match |
| rsp_multi | output | 1 | More than one full match (error) |
| rsp_row | output | 7 | Row of the hit entry |
| rsp_col | output | 3 | Column of the hit entry |
| fill_valid | input | 1 | Fill request strobe |
| fill_tag | input | 24 | Tag to install |
| fill_ack | output | 1 | Fill response strobe |
| fill_row | output | 7 | Row that received the fill |
| fill_col | output | 3 | Column that received the fill |
| fill_evict | output | 1 | Victim held a valid line |
| fill_old_tag | output | 24 | Tag of the displaced line |

## Verification
Corrupted valid bits or stored tags appear at the ports on the next lookup of the affected tag. The symptom is a false miss, a false hit or a spurious multi-match, two cycles after the request. Damaged LRU ages stay hidden until the row fills up. They then show as the wrong `fill_col` and `fill_old_tag` one cycle after the next fill to that row, so the bench fills a row completely and touches it before evicting. A drifting row generator shows on the very next `fill_row`, because the bench steps its own copy of the sequence every cycle.

// File: rtl/tcache_pkg.sv
`timescale 1ns/1ps
package tcache_pkg;

  // Feedback tap mask for a Fibonacci shift register of width w
  // (bit w-1 is the oldest bit; the new bit enters at bit 0).
  function automatic logic [31:0] lfsr_mask(int unsigned w);
    logic [31:0] m;
    case (w)
      2:       m = 32'h0000_0003;
      3:       m = 32'h0000_0006;
      4:       m = 32'h0000_000C;
      5:       m = 32'h0000_0014;
      6:       m = 32'h0000_0030;
      7:       m = 32'h0000_0060;
      8:       m = 32'h0000_00B8;
      9:       m = 32'h0000_0110;
      10:      m = 32'h0000_0240;
      default: m = 32'h0000_0060;
    endcase
    return m;
  endfunction

  // One step of the row generator.
  function automatic logic [31:0] lfsr_step(logic [31:0] s, int unsigned w);
    logic        fb;
    logic [31:0] keep;
    fb   = ^(s & lfsr_mask(w));
    keep = (32'd1 << w) - 32'd1;
    return ((s << 1) | {31'd0, fb}) & keep;
  endfunction

endpackage

// File: rtl/tcache_row_lfsr.sv
`timescale 1ns/1ps
module tcache_row_lfsr #(
  parameter int unsigned W    = 7,
  parameter int unsigned SEED = 1
) (
  input  logic         clk,
  input  logic         rst,
  output logic [W-1:0] row
);
  logic [W-1:0] st;

  always_ff @(posedge clk) begin
    if (rst) st <= W'(SEED);
    else     st <= W'(tcache_pkg::lfsr_step(32'(st), W));
  end

  assign row = st;

  // The generator must never lock up in the all-zero state.
  p_gen_nonzero_r4: assert property (@(posedge clk) disable iff (rst)
    st != '0);

  // It moves on every cycle out of reset.
  p_gen_steps_r4: assert property (@(posedge clk) disable iff (rst)
    !rst |=> st != $past(st));
endmodule

// File: rtl/tcache_row_lru.sv
`timescale 1ns/1ps
module tcache_row_lru #(
  parameter int unsigned ROWS = 128,
  parameter int unsigned COLS = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [$clog2(ROWS)-1:0]  q_row,
  input  logic [COLS-1:0]          q_valid,
  output logic [$clog2(COLS)-1:0]  victim_col,
  input  logic                     fill_we,
  input  logic [$clog2(ROWS)-1:0]  fill_row,
  input  logic [$clog2(COLS)-1:0]  fill_col,
  input  logic                     hit_we,
  input  logic [$clog2(ROWS)-1:0]  hit_row,
  input  logic [$clog2(COLS)-1:0]  hit_col
);
  localparam int unsigned COL_W = $clog2(COLS);

  typedef logic [COLS-1:0][COL_W-1:0] ages_t;

  ages_t age [ROWS];

  // Make column t the youngest; everything younger than it ages by one.
  function automatic ages_t touch(ages_t a, logic [COL_W-1:0] t);
    ages_t r;
    r = a;
    for (int c = 0; c < COLS; c++)
      if (a[c] < a[t]) r[c] = a[c] + COL_W'(1);
    r[t] = '0;
    return r;
  endfunction

  // Lowest empty column, otherwise the oldest column.
  function automatic logic [COL_W-1:0] pick(ages_t a, logic [COLS-1:0] vb);
    logic [COL_W-1:0] v;
    logic             found;
    v     = '0;
    found = 1'b0;
    for (int c = 0; c < COLS; c++)
      if (!vb[c] && !found) begin
        v     = COL_W'(c);
        found = 1'b1;
      end
    if (!found)
      for (int c = 0; c < COLS; c++)
        if (a[c] == COL_W'(COLS - 1)) v = COL_W'(c);
    return v;
  endfunction

  // Which age values occur in a row (a permutation sets every bit).
  function automatic logic [COLS-1:0] present(ages_t a);
    logic [COLS-1:0] p;
    p = '0;
    for (int c = 0; c < COLS; c++) p[a[c]] = 1'b1;
    return p;
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int r = 0; r < ROWS; r++)
        for (int c = 0; c < COLS; c++)
          age[r][c] <= COL_W'(c);
    end else if (fill_we) begin
      age[fill_row] <= touch(age[fill_row], fill_col);
    end else if (hit_we) begin
      age[hit_row] <= touch(age[hit_row], hit_col);
    end
  end

  assign victim_col = pick(age[q_row], q_valid);

  // The ages of the row under query always form a permutation.
  p_age_perm_r5: assert property (@(posedge clk) disable iff (rst)
    present(age[q_row]) == {COLS{1'b1}});

  // A filled column becomes the youngest.
  p_fill_youngest_r5: assert property (@(posedge clk) disable iff (rst)
    fill_we |=> age[$past(fill_row)][$past(fill_col)] == '0);

  // A hit column becomes the youngest when no fill competes.
  p_hit_youngest_r5: assert property (@(posedge clk) disable iff (rst)
    hit_we && !fill_we |=> age[$past(hit_row)][$past(hit_col)] == '0);
endmodule

// File: rtl/tcache_tag_store.sv
`timescale 1ns/1ps
module tcache_tag_store #(
  parameter int unsigned ROWS   = 128,
  parameter int unsigned COLS   = 8,
  parameter int unsigned TAG_W  = 24,
  parameter int unsigned PTAG_W = 12
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic [PTAG_W-1:0]            q_ptag,
  output logic [ROWS*COLS-1:0]         part_hit,
  input  logic [TAG_W-PTAG_W-1:0]      c_hi,
  input  logic [ROWS*COLS-1:0]         c_mask,
  output logic [ROWS*COLS-1:0]         full_hit,
  input  logic                         we,
  input  logic [$clog2(ROWS)-1:0]      w_row,
  input  logic [$clog2(COLS)-1:0]      w_col,
  input  logic [TAG_W-1:0]             w_tag,
  input  logic [$clog2(ROWS)-1:0]      r_row,
  input  logic [$clog2(COLS)-1:0]      r_col,
  output logic [COLS-1:0]              row_valid,
  output logic [TAG_W-1:0]             r_tag
);
  localparam int unsigned ENTRIES = ROWS * COLS;
  localparam int unsigned IDX_W   = $clog2(ENTRIES);
  localparam int unsigned HI_W    = TAG_W - PTAG_W;
  localparam int unsigned COL_W   = $clog2(COLS);

  logic [ENTRIES-1:0] valid;
  logic [PTAG_W-1:0]  ptag [ENTRIES];
  logic [HI_W-1:0]    hi   [ENTRIES];

  logic [IDX_W-1:0] widx, ridx;
  assign widx = {w_row, w_col};
  assign ridx = {r_row, r_col};

  // Parallel partial-tag compare (stage 1) and upper-tag confirm (stage 2).
  for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
    assign part_hit[i] = valid[i] && (ptag[i] == q_ptag);
    assign full_hit[i] = c_mask[i] && valid[i] && (hi[i] == c_hi);
  end

  for (genvar c = 0; c < COLS; c++) begin : g_rowv
    assign row_valid[c] = valid[{r_row, COL_W'(c)}];
  end

  assign r_tag = {hi[ridx], ptag[ridx]};

  always_ff @(posedge clk) begin
    if (rst)     valid       <= '0;
    else if (we) valid[widx] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (we) begin
      ptag[widx] <= w_tag[PTAG_W-1:0];
      hi[widx]   <= w_tag[TAG_W-1:PTAG_W];
    end
  end

  // A written entry is valid afterwards.
  p_write_marks_valid_r8: assert property (@(posedge clk) disable iff (rst)
    we |=> valid[$past(widx)]);
endmodule

// File: rtl/tcache_tag_ctrl.sv
`timescale 1ns/1ps
module tcache_tag_ctrl #(
  parameter int unsigned ROWS   = 128,
  parameter int unsigned COLS   = 8,
  parameter int unsigned TAG_W  = 24,
  parameter int unsigned PTAG_W = 12
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     lk_valid,
  input  logic [TAG_W-1:0]         lk_tag,
  output logic                     rsp_valid,
  output logic                     rsp_hit,
  output logic                     rsp_multi,
  output logic [$clog2(ROWS)-1:0]  rsp_row,
  output logic [$clog2(COLS)-1:0]  rsp_col,
  input  logic                     fill_valid,
  input  logic [TAG_W-1:0]         fill_tag,
  output logic                     fill_ack,
  output logic [$clog2(ROWS)-1:0]  fill_row,
  output logic [$clog2(COLS)-1:0]  fill_col,
  output logic                     fill_evict,
  output logic [TAG_W-1:0]         fill_old_tag
);
  localparam int unsigned ENTRIES = ROWS * COLS;
  localparam int unsigned IDX_W   = $clog2(ENTRIES);
  localparam int unsigned ROW_W   = $clog2(ROWS);
  localparam int unsigned COL_W   = $clog2(COLS);
  localparam int unsigned HI_W    = TAG_W - PTAG_W;

  // ---------------- stage 1: partial match over all entries -------------
  logic [ENTRIES-1:0] part_hit;
  logic               s1_valid;
  logic [HI_W-1:0]    s1_hi;
  logic [ENTRIES-1:0] s1_mask;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_valid <= 1'b0;
      s1_mask  <= '0;
      s1_hi    <= '0;
    end else begin
      s1_valid <= lk_valid;
      s1_mask  <= lk_valid ? part_hit : '0;
      s1_hi    <= lk_tag[TAG_W-1:PTAG_W];
    end
  end

  // ---------------- stage 2: confirm and resolve ------------------------
  logic [ENTRIES-1:0] full_hit;
  logic               any_hit, many_hit;
  logic [IDX_W-1:0]   hit_idx;

  always_comb begin
    any_hit  = 1'b0;
    many_hit = 1'b0;
    hit_idx  = '0;
    for (int i = 0; i < ENTRIES; i++)
      if (full_hit[i]) begin
        if (any_hit) many_hit = 1'b1;
        any_hit = 1'b1;
        hit_idx = IDX_W'(i);
      end
  end

  // Named events for the checks below.
  logic hit_event, multi_event;
  assign hit_event   = s1_valid && any_hit && !many_hit;
  assign multi_event = s1_valid && many_hit;

  logic [ROW_W-1:0] hit_row;
  logic [COL_W-1:0] hit_col;
  assign hit_row = hit_idx[IDX_W-1:COL_W];
  assign hit_col = hit_idx[COL_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_multi <= 1'b0;
      rsp_row   <= '0;
      rsp_col   <= '0;
    end else begin
      rsp_valid <= s1_valid;
      rsp_hit   <= hit_event;
      rsp_multi <= multi_event;
      rsp_row   <= hit_event ? hit_row : '0;
      rsp_col   <= hit_event ? hit_col : '0;
    end
  end

  // ---------------- victim selection and fill ---------------------------
  logic [ROW_W-1:0] gen_row;
  logic [COLS-1:0]  vrow_valid;
  logic [COL_W-1:0] victim_col;
  logic [TAG_W-1:0] victim_tag;
  logic             fill_event;

  assign fill_event = fill_valid;

  tcache_row_lfsr #(.W(ROW_W), .SEED(1)) u_gen (
    .clk (clk),
    .rst (rst),
    .row (gen_row)
  );

  tcache_tag_store #(
    .ROWS(ROWS), .COLS(COLS), .TAG_W(TAG_W), .PTAG_W(PTAG_W)
  ) u_store (
    .clk       (clk),
    .rst       (rst),
    .q_ptag    (lk_tag[PTAG_W-1:0]),
    .part_hit  (part_hit),
    .c_hi      (s1_hi),
    .c_mask    (s1_mask),
    .full_hit  (full_hit),
    .we        (fill_event),
    .w_row     (gen_row),
    .w_col     (victim_col),
    .w_tag     (fill_tag),
    .r_row     (gen_row),
    .r_col     (victim_col),
    .row_valid (vrow_valid),
    .r_tag     (victim_tag)
  );

  tcache_row_lru #(.ROWS(ROWS), .COLS(COLS)) u_lru (
    .clk        (clk),
    .rst        (rst),
    .q_row      (gen_row),
    .q_valid    (vrow_valid),
    .victim_col (victim_col),
    .fill_we    (fill_event),
    .fill_row   (gen_row),
    .fill_col   (victim_col),
    .hit_we     (hit_event),
    .hit_row    (hit_row),
    .hit_col    (hit_col)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      fill_ack     <= 1'b0;
      fill_row     <= '0;
      fill_col     <= '0;
      fill_evict   <= 1'b0;
      fill_old_tag <= '0;
    end else begin
      fill_ack     <= fill_event;
      fill_row     <= gen_row;
      fill_col     <= victim_col;
      fill_evict   <= fill_event && vrow_valid[victim_col];
      fill_old_tag <= victim_tag;
    end
  end

  // ---------------- checks ---------------------------------------------
  p_two_cycle_r9: assert property (@(posedge clk) disable iff (rst)
    lk_valid |=> ##1 rsp_valid);

  p_hit_excl_r7: assert property (@(posedge clk) disable iff (rst)
    rsp_multi |-> !rsp_hit && rsp_valid);

  p_victim_empty_r6: assert property (@(posedge clk) disable iff (rst)
    fill_valid && !(&vrow_valid) |-> !vrow_valid[victim_col]);

  p_fill_ack_r8: assert property (@(posedge clk) disable iff (rst)
    fill_valid |=> fill_ack);

  p_miss_zero_loc_r3: assert property (@(posedge clk) disable iff (rst)
    rsp_valid && !rsp_hit |-> rsp_row == '0 && rsp_col == '0);
endmodule

// File: tb/test_tcache_tag_ctrl.sv
`timescale 1ns/1ps
module test_tcache_tag_ctrl;
  localparam int NR = 128;
  localparam int NC = 8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        lk_valid = 1'b0;
  logic [23:0] lk_tag = '0;
  logic        rsp_valid, rsp_hit, rsp_multi;
  logic [6:0]  rsp_row;
  logic [2:0]  rsp_col;
  logic        fill_valid = 1'b0;
  logic [23:0] fill_tag = '0;
  logic        fill_ack, fill_evict;
  logic [6:0]  fill_row;
  logic [2:0]  fill_col;
  logic [23:0] fill_old_tag;

  always #10 clk = ~clk;   // 50 MHz

  tcache_tag_ctrl i_tcache_tag_ctrl (
    .clk(clk), .rst(rst),
    .lk_valid(lk_valid), .lk_tag(lk_tag),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_multi(rsp_multi),
    .rsp_row(rsp_row), .rsp_col(rsp_col),
    .fill_valid(fill_valid), .fill_tag(fill_tag),
    .fill_ack(fill_ack), .fill_row(fill_row), .fill_col(fill_col),
    .fill_evict(fill_evict), .fill_old_tag(fill_old_tag)
  );

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  bit finished = 0;

  always @(posedge clk) cyc <= cyc + 1;

  // ---------------- reference model ----------------
  logic [6:0]  m_gen;
  bit          mv [NR][NC];
  logic [23:0] mt [NR][NC];
  int          ma [NR][NC];

  always @(posedge clk)
    if (rst) m_gen <= 7'h01;
    else     m_gen <= {m_gen[5:0], m_gen[6] ^ m_gen[5]};

  task automatic model_reset();
    for (int r = 0; r < NR; r++)
      for (int c = 0; c < NC; c++) begin
        mv[r][c] = 0; mt[r][c] = '0; ma[r][c] = c;
      end
  endtask

  task automatic m_touch(int r, int t);
    int old = ma[r][t];
    for (int c = 0; c < NC; c++)
      if (ma[r][c] < old) ma[r][c]++;
    ma[r][t] = 0;
  endtask

  typedef struct {
    int due; bit hit; bit multi; int row; int col; string req;
  } lk_exp_t;
  typedef struct {
    int due; int row; int col; bit evict; logic [23:0] old; string req;
  } fl_exp_t;

  lk_exp_t lq[$];
  fl_exp_t fq[$];

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // ---------------- drivers ----------------
  task automatic do_lookup(logic [23:0] tag, string req);
    int n = 0, hr = 0, hc = 0;
    lk_exp_t e;
    for (int r = 0; r < NR; r++)
      for (int c = 0; c < NC; c++)
        if (mv[r][c] && mt[r][c] == tag) begin n++; hr = r; hc = c; end
    e.due = cyc + 2; e.hit = (n == 1); e.multi = (n > 1);
    e.row = hr; e.col = hc; e.req = req;
    lq.push_back(e);
    if (n == 1) m_touch(hr, hc);
    lk_valid = 1'b1; lk_tag = tag;
    @(negedge clk);
    lk_valid = 1'b0;
  endtask

  task automatic do_fill(logic [23:0] tag, int target);
    int r, v;
    fl_exp_t f;
    while (target >= 0 && int'(m_gen) != target) @(negedge clk);
    r = int'(m_gen);
    v = -1;
    for (int c = 0; c < NC; c++) if (!mv[r][c] && v < 0) v = c;
    if (v < 0) for (int c = 0; c < NC; c++) if (ma[r][c] == NC - 1) v = c;
    f.due = cyc + 1; f.row = r; f.col = v; f.evict = mv[r][v];
    f.old = mt[r][v]; f.req = mv[r][v] ? "R5" : "R6";
    fq.push_back(f);
    mv[r][v] = 1; mt[r][v] = tag; m_touch(r, v);
    fill_valid = 1'b1; fill_tag = tag;
    @(negedge clk);
    fill_valid = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  // ---------------- monitor / scoreboard ----------------
  always @(negedge clk) begin : mon
    lk_exp_t e;
    fl_exp_t f;
    if (!rst && !finished) begin
      if (rsp_valid) begin
        if (lq.size() == 0) chk(0, "R9", "unexpected response", 1, 0);
        else begin
          e = lq.pop_front();
          chk(cyc == e.due, "R9", "response cycle", cyc, e.due);
          chk(rsp_hit == e.hit, e.req, "hit flag", rsp_hit, e.hit);
          chk(rsp_multi == e.multi, "R7", "multi flag", rsp_multi, e.multi);
          if (e.hit) begin
            chk(rsp_row == e.row, "R3", "hit row", rsp_row, e.row);
            chk(rsp_col == e.col, "R3", "hit col", rsp_col, e.col);
          end else begin
            chk(rsp_row == 0 && rsp_col == 0, "R3", "miss location",
                {rsp_row, rsp_col}, 0);
          end
        end
      end
      if (fill_ack) begin
        if (fq.size() == 0) chk(0, "R8", "unexpected fill ack", 1, 0);
        else begin
          f = fq.pop_front();
          chk(cyc == f.due, "R8", "fill ack cycle", cyc, f.due);
          chk(fill_row == f.row, "R4", "fill row", fill_row, f.row);
          chk(fill_col == f.col, f.req, "fill col", fill_col, f.col);
          chk(fill_evict == f.evict, "R8", "evict flag", fill_evict, f.evict);
          if (f.evict)
            chk(fill_old_tag == f.old, "R8", "old tag", fill_old_tag, f.old);
        end
      end
    end
  end

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    #(20 * 150000);
    chk(0, "R9", "watchdog expired", cyc, 0);
    finish_run();
  end

  // ---------------- stimulus ----------------
  localparam logic [23:0] TA = 24'h5A3C71;
  localparam logic [23:0] TB = 24'h7E0E0E;

  initial begin
    model_reset();
    rst = 1'b1;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    // R1: outputs idle after reset
    chk(rsp_valid == 0, "R1", "rsp_valid after reset", rsp_valid, 0);
    chk(fill_ack == 0, "R1", "fill_ack after reset", fill_ack, 0);

    // R1: empty cache misses
    do_lookup(24'h000123, "R1");
    do_lookup(24'hABCDEF, "R1");
    idle(3);

    // R4/R6: fill at generator row
    do_fill(TA, -1);
    do_lookup(TA, "R3");
    do_lookup(TA ^ 24'h001000, "R2");   // upper field differs
    do_lookup(TA ^ 24'h000001, "R2");   // partial field differs
    idle(3);

    // R6/R5: fill row 5 completely, touch, then evict
    for (int k = 0; k < NC; k++) do_fill(24'h100000 + 24'(k * 24'h1011), 5);
    do_lookup(24'h100000, "R5");
    do_lookup(24'h100000 + 24'h1011 * 3, "R5");
    idle(3);
    do_fill(24'h2468AC, 5);
    do_lookup(24'h2468AC, "R3");
    do_lookup(24'h100000 + 24'h1011, "R5");   // most likely evicted
    idle(3);
    do_fill(24'h2468AD, 5);
    do_fill(24'h2468AE, 5);
    idle(3);

    // R7: duplicate tag installed twice
    do_fill(TB, 20);
    do_fill(TB, 20);
    do_lookup(TB, "R7");
    idle(3);

    // R4: a few fills at arbitrary times
    do_fill(24'h0F0F0F, -1);
    idle(2);
    do_fill(24'h0F0F10, -1);
    idle(7);
    do_fill(24'h0F0F11, -1);
    idle(3);

    // R9: back-to-back lookups
    do_lookup(TA, "R9");
    do_lookup(24'h100000 + 24'h1011 * 2, "R9");
    do_lookup(24'h2468AE, "R9");
    do_lookup(TB, "R9");
    do_lookup(24'h0F0F10, "R9");
    do_lookup(24'h999999, "R9");
    idle(6);

    chk(lq.size() == 0, "R9", "lookups left unanswered", lq.size(), 0);
    chk(fq.size() == 0, "R8", "fills left unacknowledged", fq.size(), 0);
    finish_run();
  end
endmodule